// File: doc/BRIEF.md
# Capture Clock Ratio Meter

This block measures how many reference clock cycles fit into one period of an unrelated capture clock. It returns that ratio as an unsigned fixed-point number with 9 integer bits and 8 fractional bits, so software can load the value straight into a fractional display clock divider. The capture clock arrives on its own asynchronous input. It is sampled into the reference domain by a short flop chain, and its rising edges are detected there.

Software pulses the start input while the block is ready. The block clears its previous outcome, drops ready, and waits for a first capture edge. It then counts reference cycles across 256 further capture periods; because the window is 256 periods long, the count is the ratio scaled by 2^8 with no division needed. The run ends in one of three ways: a valid result, a missing-clock error when edges stop arriving, or a slow-clock error when the count no longer fits in 17 bits. A second output gives the result halved with rounding, for display paths that divide the generated clock by two.

Top module: `cap_ratio_meter`

## Requirements
- R1: After reset, ready is 1, both error flags are 0 and the result is 0.
- R2: A start pulse seen while ready is 1 drives ready to 0 on the next cycle and clears the result and both error flags to 0.
- R3: A successful run returns the number of reference cycles spanning 256 capture periods, which is the ratio times 256 in 9.8 format, within one LSB.
- R4: Ready returns to 1 when a run ends, and the result and flags then hold their values until the next accepted start.
- R5: If no capture rising edge is seen for TIMEOUT reference cycles during a run, the missing-clock flag is set, ready returns to 1 and the result stays 0.
- R6: If the count reaches 2^17 (ratio of 512 or more) before the window closes, the slow-clock flag is set, counting stops, ready returns to 1 and the result stays 0.
- R7: The two error flags are never set together, and a run that ends with a nonzero result leaves both flags at 0.
- R8: A start pulse while ready is 0 is ignored: the run in progress continues and ends at its original time.
- R9: The halved output always equals (result + 1) shifted right by one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low reset, reference domain |
| cap_clk_i | input | 1 | Asynchronous capture clock to be measured |
| start_i | input | 1 | One-cycle pulse that requests a measurement |
| ready_o | output | 1 | 1 when idle; 0 while a run is in progress |
| err_noclk_o | output | 1 | Capture clock was not seen |
| err_slow_o | output | 1 | Capture clock too slow to give a valid ratio |
| ratio_o | output | 17 | Ratio in unsigned 9.8 fixed point |
| ratio_half_o | output | 17 | Ratio halved with rounding, 9.8 fixed point |

## Verification
The assertions assume that start is a clean synchronous pulse in the reference domain and that reset is applied before the first start. They also assume the capture clock is either stable in frequency for a whole run or stopped outright. The bench drives start only on falling reference edges for exactly one cycle. It changes the capture period or gates the capture clock only while the block is idle, so every run sees a single steady capture rate.

// File: rtl/cap_ratio_meter.sv
`timescale 1ns/1ps
module cap_ratio_meter #(
  parameter int INT_W   = 9,
  parameter int FRAC_W  = 8,
  parameter int TIMEOUT = 1024,
  parameter int SYNC    = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cap_clk_i,
  input  logic                      start_i,
  output logic                      ready_o,
  output logic                      err_noclk_o,
  output logic                      err_slow_o,
  output logic [INT_W+FRAC_W-1:0]   ratio_o,
  output logic [INT_W+FRAC_W-1:0]   ratio_half_o
);

  localparam int RW    = INT_W + FRAC_W;
  localparam int EDGES = 1 << FRAC_W;
  localparam int TW    = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_RUN} state_t;

  state_t            st;
  logic [SYNC:0]     cap_sh;
  logic [RW-1:0]     cnt, res;
  logic [FRAC_W-1:0] edges;
  logic [TW-1:0]     gap;
  logic              e_nc, e_sl;
  logic              cap_rise, gap_out;
  logic [RW:0]       nxt;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cap_sh <= '0;
    else         cap_sh <= {cap_sh[SYNC-1:0], cap_clk_i};

  assign cap_rise = cap_sh[SYNC-1] & ~cap_sh[SYNC];
  assign gap_out  = (gap == TW'(TIMEOUT - 1)) & ~cap_rise;
  assign nxt      = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st    <= S_IDLE;
      cnt   <= '0;
      res   <= '0;
      edges <= '0;
      gap   <= '0;
      e_nc  <= 1'b0;
      e_sl  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          st    <= S_ARM;
          res   <= '0;
          e_nc  <= 1'b0;
          e_sl  <= 1'b0;
          gap   <= '0;
          cnt   <= '0;
          edges <= '0;
        end
        S_ARM: begin
          if (cap_rise) begin
            st    <= S_RUN;
            gap   <= '0;
            cnt   <= '0;
            edges <= '0;
          end else if (gap_out) begin
            e_nc <= 1'b1;
            st   <= S_IDLE;
          end else begin
            gap <= gap + 1'b1;
          end
        end
        S_RUN: begin
          cnt <= nxt[RW-1:0];
          gap <= cap_rise ? '0 : gap + 1'b1;
          if (nxt[RW]) begin
            e_sl <= 1'b1;
            st   <= S_IDLE;
          end else if (cap_rise && edges == FRAC_W'(EDGES - 1)) begin
            res <= nxt[RW-1:0];
            st  <= S_IDLE;
          end else if (cap_rise) begin
            edges <= edges + 1'b1;
          end else if (gap_out) begin
            e_nc <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ready_o      = (st == S_IDLE);
  assign err_noclk_o  = e_nc;
  assign err_slow_o   = e_sl;
  assign ratio_o      = res;
  assign ratio_half_o = RW'(({1'b0, res} + 1'b1) >> 1);

endmodule

module cap_ratio_meter_chk #(
  parameter int RW = 17
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          ready_o,
  input logic          err_noclk_o,
  input logic          err_slow_o,
  input logic [RW-1:0] ratio_o
);

  a_r2_start_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i) |=> !ready_o);

  a_r2_busy_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (ratio_o == '0 && !err_noclk_o && !err_slow_o));

  a_r4_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> ($stable(ratio_o) && $stable(err_noclk_o) && $stable(err_slow_o)));

  a_r7_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_noclk_o && err_slow_o));

  a_r7_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ((ratio_o != '0) != (err_noclk_o || err_slow_o)));

  a_r8_busy_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && start_i && $past(!ready_o)) |=> (ratio_o == '0));

endmodule

bind cap_ratio_meter cap_ratio_meter_chk #(.RW(INT_W + FRAC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .ready_o    (ready_o),
  .err_noclk_o(err_noclk_o),
  .err_slow_o (err_slow_o),
  .ratio_o    (ratio_o)
);

// File: tb/cap_ratio_meter_bench.sv
`timescale 1ns/1ps
module cap_ratio_meter_bench;

  localparam int TMO = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_clk = 1'b0;
  logic        start = 1'b0;
  logic        ready, e_nc, e_sl;
  logic [16:0] ratio, half;

  real cap_half = 20.0;
  bit  cap_en = 1'b1;
  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  always begin
    if (cap_en) begin
      #(cap_half) cap_clk = ~cap_clk;
    end else begin
      cap_clk = 1'b0;
      wait (cap_en);
    end
  end

  cap_ratio_meter #(.TIMEOUT(TMO)) u_cap_ratio_meter (
    .clk_i(clk), .rst_ni(rst_n), .cap_clk_i(cap_clk), .start_i(start),
    .ready_o(ready), .err_noclk_o(e_nc), .err_slow_o(e_sl),
    .ratio_o(ratio), .ratio_half_o(half)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_ready(input int limit, output int cyc);
    cyc = 0;
    while (!ready && cyc < limit) begin
      @(negedge clk); cyc++;
    end
  endtask

  task automatic t_reset();
    chk(ready == 1'b1, "R1 ready", int'(ready), 1);
    chk(e_nc == 1'b0 && e_sl == 1'b0, "R1 flags", int'({e_nc, e_sl}), 0);
    chk(ratio == 17'd0, "R1 result", int'(ratio), 0);
  endtask

  task automatic t_ratio(input real hp, input int exp);
    int cyc;
    logic [16:0] r;
    cap_half = hp;
    pulse_start();
    chk(ready == 1'b0, "R2 ready low", int'(ready), 0);
    wait_ready(4000, cyc);
    r = ratio;
    chk(ready == 1'b1, "R4 ready back", int'(ready), 1);
    chk(int'(r) >= exp - 1 && int'(r) <= exp + 1, "R3 ratio", int'(r), exp);
    chk(e_nc == 1'b0 && e_sl == 1'b0, "R7 flags clear", int'({e_nc, e_sl}), 0);
    chk(int'(half) == (int'(r) + 1) / 2, "R9 half", int'(half), (int'(r) + 1) / 2);
    repeat (50) @(negedge clk);
    chk(ratio == r, "R4 result held", int'(ratio), int'(r));
  endtask

  task automatic t_busy();
    int c1, c2;
    cap_half = 20.0;
    pulse_start();
    repeat (500) @(negedge clk);
    chk(ready == 1'b0, "R8 busy", int'(ready), 0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_ready(4000, c2);
    c1 = 502 + c2;
    chk(c1 < 1300, "R8 end time", c1, 1030);
    chk(int'(ratio) >= 1023 && int'(ratio) <= 1025, "R8 ratio", int'(ratio), 1024);
  endtask

  task automatic t_noclk();
    int cyc;
    cap_en = 1'b0;
    repeat (5) @(negedge clk);
    pulse_start();
    wait_ready(3 * TMO, cyc);
    chk(ready == 1'b1 && cyc >= TMO - 10 && cyc <= TMO + 10, "R5 timeout", cyc, TMO);
    chk(e_nc == 1'b1, "R5 noclk flag", int'(e_nc), 1);
    chk(e_sl == 1'b0, "R7 slow clear", int'(e_sl), 0);
    chk(ratio == 17'd0, "R5 result zero", int'(ratio), 0);
  endtask

  task automatic t_clear();
    int cyc;
    cap_half = 20.0;
    cap_en = 1'b1;
    pulse_start();
    chk(e_nc == 1'b0 && e_sl == 1'b0, "R2 flags cleared", int'({e_nc, e_sl}), 0);
    chk(ratio == 17'd0, "R2 result cleared", int'(ratio), 0);
    wait_ready(4000, cyc);
    chk(int'(ratio) >= 1023 && int'(ratio) <= 1025, "R3 after error", int'(ratio), 1024);
  endtask

  task automatic t_slow();
    int cyc;
    cap_half = 3000.0;
    repeat (700) @(negedge clk);
    pulse_start();
    wait_ready(140000, cyc);
    chk(ready == 1'b1, "R6 ready", int'(ready), 1);
    chk(e_sl == 1'b1, "R6 slow flag", int'(e_sl), 1);
    chk(e_nc == 1'b0, "R7 noclk clear", int'(e_nc), 0);
    chk(ratio == 17'd0, "R6 result zero", int'(ratio), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ratio(20.0, 1024);
    t_ratio(16.5, 845);
    t_ratio(25.0, 1280);
    t_busy();
    t_noclk();
    t_clear();
    t_slow();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule